// File: doc/BRIEF.md
# Streaming Colour Lookup Table Write Port

This block holds a 256-entry colour lookup table of 24-bit red/green/blue entries. Software loads it through two byte-wide ports. A write to the index port picks the entry to load. Three writes to the data port follow, carrying the red, green and blue bytes. The entry changes only when the blue byte arrives, and the write index then advances by one. A whole table, or any run of consecutive entries, can therefore be streamed after a single index write.

On the display side a pixel value addresses the table. The pixel first passes through an AND with a programmable pixel mask. The selected entry appears on a registered output one clock later. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `pal_stream_clut`

## Requirements
- R1: After reset every table entry reads as 0x000000, the pixel mask is 0xFF, the write index is 0, the byte phase is red and `pix_out` is 0.
- R2: A write to the index port loads the write index from `wdata` and returns the byte phase to red. Any red or green byte already staged is discarded.
- R3: Data-port bytes are taken in the order red, green, blue. In the committed entry, red sits in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: A table entry keeps its old value after the red byte and after the green byte. It takes the new value only at the clock edge that accepts the blue byte, so a half-written colour is never seen on the lookup path.
- R5: After each commit the write index increases by one, wrapping from 255 to 0, and the phase returns to red.
- R6: `pix_out` equals the entry at address (`pix_in` AND mask), registered at the rising clock edge, so it has one cycle of latency.
- R7: A mask write loads the mask from `wdata`. It takes effect for lookups registered on later clock edges.
- R8: If the index strobe and the data strobe are high in the same cycle, the index write is performed and the data byte is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| idx_we | input | 1 | Write strobe for the index port |
| data_we | input | 1 | Write strobe for the colour data port |
| mask_we | input | 1 | Write strobe for the pixel mask |
| wdata | input | 8 | Byte written by whichever strobe is active |
| pix_in | input | 8 | Pixel value for lookup |
| pix_out | output | 24 | Looked-up colour {red, green, blue}, registered |

## Verification
The assertions check the sequencer on every cycle:
- after an index write, the phase is red and the index holds the written byte;
- each accepted byte moves the phase on by one step;
- a commit happens only in the blue phase and never alongside an index write;
- after a commit, the index has stepped by one and the phase is back at red.

The colour contents need the bench's scenarios to be shown. These cover:
- the byte-to-field placement;
- that entries stay unchanged in the middle of a sequence;
- the wrap of a stream from entry 255 to entry 0;
- masking of the pixel address;
- the one-cycle lookup latency.

The bench checks these against a reference table that it keeps itself.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } pal_phase_e;
endpackage

// File: rtl/pal_seq.sv
// Byte-phase sequencer: stages red and green, commits on blue, steps the index.
module pal_seq
  import pal_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 8,
  localparam int RGBW = 3 * CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idx_we,
  input  logic            data_we,
  input  logic [CW-1:0]   wdata,
  output logic            commit,
  output logic [AW-1:0]   commit_idx,
  output logic [RGBW-1:0] commit_rgb,
  output pal_phase_e      phase,
  output logic [AW-1:0]   wr_idx
);
  pal_phase_e    phase_q, phase_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [CW-1:0] red_q, red_d, grn_q, grn_d;
  logic          take_byte;

  assign take_byte = data_we && !idx_we;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    red_d   = red_q;
    grn_d   = grn_q;
    commit  = 1'b0;
    if (idx_we) begin
      idx_d   = wdata[AW-1:0];
      phase_d = PH_RED;
    end else if (take_byte) begin
      unique case (phase_q)
        PH_RED: begin
          red_d   = wdata;
          phase_d = PH_GRN;
        end
        PH_GRN: begin
          grn_d   = wdata;
          phase_d = PH_BLU;
        end
        default: begin
          commit  = 1'b1;
          idx_d   = idx_q + AW'(1);
          phase_d = PH_RED;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RED;
      idx_q   <= '0;
      red_q   <= '0;
      grn_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      red_q   <= red_d;
      grn_q   <= grn_d;
    end
  end

  assign commit_idx = idx_q;
  assign commit_rgb = {red_q, grn_q, wdata};
  assign phase      = phase_q;
  assign wr_idx     = idx_q;
endmodule

// File: rtl/pal_store.sv
// Entry storage, pixel mask and registered lookup.
module pal_store #(
  parameter int CW = 8,
  parameter int AW = 8,
  localparam int RGBW = 3 * CW,
  localparam int NENT = 1 << AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit,
  input  logic [AW-1:0]   commit_idx,
  input  logic [RGBW-1:0] commit_rgb,
  input  logic            mask_we,
  input  logic [AW-1:0]   mask_wdata,
  input  logic [AW-1:0]   pix_in,
  output logic [RGBW-1:0] pix_out
);
  logic [RGBW-1:0] ent_arr [NENT];
  logic [AW-1:0]   mask_q;
  logic [RGBW-1:0] look_d, look_q;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic            ent_en;
    logic [RGBW-1:0] ent_q;
    assign ent_en = commit && (commit_idx == AW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= commit_rgb;
    end
    assign ent_arr[e] = ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign look_d = ent_arr[pix_in & mask_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) look_q <= '0;
    else        look_q <= look_d;
  end

  assign pix_out = look_q;
endmodule

// File: rtl/pal_stream_clut.sv
module pal_stream_clut
  import pal_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              data_we,
  input  logic              mask_we,
  input  logic [CW-1:0]     wdata,
  input  logic [AW-1:0]     pix_in,
  output logic [3*CW-1:0]   pix_out
);
  localparam int RGBW = 3 * CW;

  logic [1:0]      rst_sync_q;
  logic            rst_sync_n;
  logic            commit;
  logic [AW-1:0]   commit_idx;
  logic [RGBW-1:0] commit_rgb;
  pal_phase_e      phase;
  logic [AW-1:0]   wr_idx;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pal_seq #(.CW(CW), .AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .idx_we     (idx_we),
    .data_we    (data_we),
    .wdata      (wdata),
    .commit     (commit),
    .commit_idx (commit_idx),
    .commit_rgb (commit_rgb),
    .phase      (phase),
    .wr_idx     (wr_idx)
  );

  pal_store #(.CW(CW), .AW(AW)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .commit     (commit),
    .commit_idx (commit_idx),
    .commit_rgb (commit_rgb),
    .mask_we    (mask_we),
    .mask_wdata (wdata[AW-1:0]),
    .pix_in     (pix_in),
    .pix_out    (pix_out)
  );
endmodule

// File: rtl/pal_stream_clut_chk.sv
module pal_stream_clut_chk #(
  parameter int CW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idx_we,
  input logic          data_we,
  input logic [CW-1:0] wdata,
  input logic          commit,
  input logic [1:0]    phase,
  input logic [AW-1:0] wr_idx
);
  a_r1_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> (phase == 2'd0) && (wr_idx == $past(wdata[AW-1:0])));

  a_r3_red_to_green: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !idx_we && phase == 2'd0) |=> phase == 2'd1);

  a_r3_green_to_blue: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !idx_we && phase == 2'd1) |=> phase == 2'd2);

  a_r4_commit_on_blue: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (phase == 2'd2) && data_we);

  a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (wr_idx == $past(wr_idx) + AW'(1)) && (phase == 2'd0));

  a_r8_index_wins: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |-> !commit);
endmodule

bind pal_stream_clut pal_stream_clut_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .idx_we  (idx_we),
  .data_we (data_we),
  .wdata   (wdata),
  .commit  (commit),
  .phase   (phase),
  .wr_idx  (wr_idx)
);

// File: tb/tb_pal_stream_clut.sv
module tb_pal_stream_clut;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, idx_we, data_we, mask_we;
  logic [7:0]  wdata, pix_in;
  logic [23:0] pix_out;

  int total = 0;
  int bad   = 0;

  logic [23:0] exp_mem [256];
  logic [7:0]  exp_idx, exp_mask, st_r, st_g;
  int          exp_ph;

  pal_stream_clut dut (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we),
    .mask_we(mask_we), .wdata(wdata), .pix_in(pix_in), .pix_out(pix_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] pack_rgb(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    return {r, g, b};
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge with the model updated
  task automatic op(bit iw, bit dw, bit mw, logic [7:0] d);
    idx_we = iw; data_we = dw; mask_we = mw; wdata = d;
    @(negedge clk);
    if (iw) begin
      exp_idx = d; exp_ph = 0;
    end else if (dw) begin
      case (exp_ph)
        0: begin st_r = d; exp_ph = 1; end
        1: begin st_g = d; exp_ph = 2; end
        default: begin
          exp_mem[exp_idx] = pack_rgb(st_r, st_g, d);
          exp_idx = exp_idx + 8'd1;
          exp_ph = 0;
        end
      endcase
    end
    if (mw) exp_mask = d;
    idx_we = 0; data_we = 0; mask_we = 0;
  endtask

  task automatic look(string req, logic [7:0] p);
    idx_we = 0; data_we = 0; mask_we = 0; pix_in = p;
    @(negedge clk);
    check(req, pix_out, exp_mem[p & exp_mask]);
  endtask

  task automatic put_rgb(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    op(0, 1, 0, r); op(0, 1, 0, g); op(0, 1, 0, b);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] saved;
    int unused;
    unused = $urandom(32'd1234);
    for (int i = 0; i < 256; i++) exp_mem[i] = '0;
    exp_idx = 0; exp_mask = 8'hFF; exp_ph = 0; st_r = 0; st_g = 0;
    rst_n = 0; idx_we = 0; data_we = 0; mask_we = 0; wdata = 0; pix_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 out", pix_out, 24'h0);
    look("R1 entry0", 8'h00);
    look("R1 entry255", 8'hFF);
    // R1: index starts at 0, phase red
    put_rgb(8'h01, 8'h02, 8'h03);
    look("R1 R3 first stream lands at 0", 8'h00);

    // R3: byte placement
    op(1, 0, 0, 8'd10);
    put_rgb(8'h11, 8'h22, 8'h33);
    look("R3 order", 8'd10);
    check("R3 value", exp_mem[10], 24'h112233);

    // R4: no partial update
    op(1, 0, 0, 8'd20);
    op(0, 1, 0, 8'hA1);
    look("R4 after red", 8'd20);
    op(0, 1, 0, 8'hA2);
    look("R4 after green", 8'd20);
    op(0, 1, 0, 8'hA3);
    look("R4 after blue", 8'd20);

    // R2: index write restarts sequence
    op(1, 0, 0, 8'd30);
    op(0, 1, 0, 8'hAA);
    op(0, 1, 0, 8'hBB);
    op(1, 0, 0, 8'd30);
    put_rgb(8'h04, 8'h05, 8'h06);
    look("R2 restart", 8'd30);

    // R5: streaming with wrap
    op(1, 0, 0, 8'd255);
    put_rgb(8'hF1, 8'hF2, 8'hF3);
    put_rgb(8'hE1, 8'hE2, 8'hE3);
    look("R5 entry255", 8'd255);
    look("R5 wrap to 0", 8'd0);
    put_rgb(8'hD1, 8'hD2, 8'hD3);
    look("R5 entry1", 8'd1);

    // R6: one-cycle latency
    pix_in = 8'd10;
    @(negedge clk);
    pix_in = 8'd255;
    check("R6 latency old", pix_out, 24'h112233);
    @(negedge clk);
    check("R6 latency new", pix_out, 24'hF1F2F3);

    // R7: mask
    op(0, 0, 1, 8'h0F);
    look("R7 masked", 8'hFA);
    look("R7 masked 2", 8'h1E);
    op(0, 0, 1, 8'hFF);
    look("R7 unmasked", 8'hFA);

    // R8: simultaneous strobes
    op(1, 0, 0, 8'd50);
    op(0, 1, 0, 8'h77);
    saved = exp_mem[50];
    op(1, 1, 0, 8'd40);
    look("R8 old entry untouched", 8'd50);
    check("R8 model", exp_mem[50], saved);
    put_rgb(8'h41, 8'h42, 8'h43);
    look("R8 new index", 8'd40);

    // random mix; R2 R3 R4 R5 R6 R7 R8
    for (int n = 0; n < 3000; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k == 0)      op(1, 0, 0, 8'($urandom));
      else if (k == 1) op(0, 0, 1, ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF);
      else if (k == 2) op(1, 1, 0, 8'($urandom));
      else if (k < 7)  op(0, 1, 0, 8'($urandom));
      else             look("R6 random lookup", 8'($urandom));
    end

    op(0, 0, 1, 8'hFF);
    for (int i = 0; i < 256; i++) look("R6 final sweep", 8'(i));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule